// File: doc/BRIEF.md
# Page Load Buffer with Idle Timeout

This block gathers the data for one page-program operation. Once the command decoder has accepted a page program command, it pulses `arm` and gives the data width on `arm_word`. The block then opens a load window. Each load arrives as two strobes. `ld_start` carries the byte address, and the address is captured on that strobe. `ld_end` carries the data, and the data is captured on that strobe. Loads may come in any order. A repeated offset replaces the earlier value. A load that points outside the page chosen by the first accepted load is refused, and a sticky error flag is set.

The window closes in one of two ways. Either a programmable number of `tick` pulses passes with no completed load, or every byte of the 128-byte page has been written. When it closes, the block issues a single `pgm_start` pulse. It then holds the page address, the 1024-bit page image and a per-byte loaded mask for the programming engine. Any byte that was never loaded reads as FFh. `tick` stands in for a microsecond time base.

Top module: `page_load_buf`

## Requirements
- R1: After reset `loading`, `pgm_start` and `page_err` are 0, `pgm_loaded` is all zeros, `pgm_data` is all ones and `pgm_page` is 0.
- R2: A one-cycle `arm` opens the window (`loading`=1 after the edge). The same edge sets every byte to FFh, clears `pgm_loaded` and `page_err`, and latches `arm_word` as the width for the whole window.
- R3: In byte mode (`arm_word`=0) a load writes `ld_data[7:0]` to the byte at offset `ld_addr[6:0]`. The offset is taken when `ld_start` is seen, and the data when `ld_end` is seen. The address lines and `ld_data[15:8]` are ignored at other times.
- R4: In word mode (`arm_word`=1) a load writes word offset `ld_addr[6:1]`. `ld_data[7:0]` goes to byte 2k and `ld_data[15:8]` goes to byte 2k+1, and `ld_addr[0]` is ignored.
- R5: Loads may target offsets in any order. A second load to the same offset replaces the stored value, and the loaded flags only accumulate within a window.
- R6: In the handed-off image, each byte never loaded in the window is FFh with its `pgm_loaded` bit 0, and each loaded byte has its bit at 1. Byte i sits at `pgm_data[8i+7:8i]`.
- R7: The window closes on the edge that sees the TIMEOUT_TICKS-th `tick` since `arm` or since the latest accepted `ld_end`, unless that edge also completes a load. On that edge `loading` falls and `pgm_start` rises.
- R8: When all 128 loaded flags are set, the window closes on the next clock edge, with no further ticks needed.
- R9: The page is `ld_addr[20:7]` of the first accepted load and is shown on `pgm_page`. A later `ld_start` with a different page is refused: no byte is written and no timer restart occurs. It also sets `page_err`, which stays at 1 until the next `arm`.
- R10: With the window closed, `ld_start`/`ld_end` change neither `pgm_data` nor `pgm_loaded`. A change of `arm_word` inside a window has no effect.
- R11: `pgm_start` is high for exactly one cycle per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Page program accepted; opens a window |
| arm_word | input | 1 | Width at arm time: 1 word, 0 byte |
| tick | input | 1 | Time-base pulse counted by the idle timer |
| ld_start | input | 1 | Load begins; address captured |
| ld_addr | input | 21 | Byte address, bit 0 is the low byte select |
| ld_end | input | 1 | Load ends; data captured |
| ld_data | input | 16 | Load data |
| loading | output | 1 | Window open |
| pgm_start | output | 1 | One-cycle start for the programming engine |
| pgm_page | output | 14 | Page address |
| pgm_data | output | 1024 | Page image, byte i at bits 8i+7:8i |
| pgm_loaded | output | 128 | Per-byte loaded flags |
| page_err | output | 1 | A load to a foreign page was refused |

## Verification
Sparse byte loads in scrambled order with one offset repeated show that placement, overwrite and FFh fill are separate behaviours. Moving the address between the two strobes shows that the offset is captured at the start strobe. Word loads with address bit 0 set and a toggled width line show word placement and the width latch. One load to a foreign page shows that it is refused. Complete fills in reverse byte order and in word order tell a close caused by a full buffer from a close caused by the timer. Windows with no loads and with ticks at different spacings pin down the exact closing edge against the behavioural model, which is compared on every clock.

// File: rtl/page_load_buf.sv
module page_load_buf #(
  parameter int PAGE_BYTES    = 128,
  parameter int ADDR_W        = 21,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm,
  input  logic                    arm_word,
  input  logic                    tick,
  input  logic                    ld_start,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic                    ld_end,
  input  logic [15:0]             ld_data,
  output logic                    loading,
  output logic                    pgm_start,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pgm_page,
  output logic [8*PAGE_BYTES-1:0] pgm_data,
  output logic [PAGE_BYTES-1:0]   pgm_loaded,
  output logic                    page_err
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(TIMEOUT_TICKS + 1);

  logic             word_q, have_page, pend;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt;

  wire [PAGE_W-1:0] pg_in   = ld_addr[ADDR_W-1:OFF_W];
  wire              page_ok = !have_page || (pg_in == pgm_page);
  wire              hit_end = loading && ld_end && pend;
  wire              full    = &pgm_loaded;
  wire              expire  = tick && (cnt == CNT_W'(TIMEOUT_TICKS - 1)) && !hit_end;
  wire              close   = loading && !arm && (full || expire);
  wire              wr      = hit_end && !close && !arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      pgm_start <= 1'b0;
      word_q    <= 1'b0;
      have_page <= 1'b0;
      pend      <= 1'b0;
      page_err  <= 1'b0;
      off_q     <= '0;
      cnt       <= '0;
      pgm_page  <= '0;
    end else begin
      pgm_start <= 1'b0;
      if (arm) begin
        loading   <= 1'b1;
        word_q    <= arm_word;
        have_page <= 1'b0;
        pend      <= 1'b0;
        page_err  <= 1'b0;
        cnt       <= '0;
      end else if (close) begin
        loading   <= 1'b0;
        pgm_start <= 1'b1;
        pend      <= 1'b0;
      end else if (loading) begin
        if (hit_end) begin
          cnt  <= '0;
          pend <= 1'b0;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
        if (ld_start) begin
          if (page_ok) begin
            pend      <= 1'b1;
            off_q     <= ld_addr[OFF_W-1:0];
            have_page <= 1'b1;
            pgm_page  <= pg_in;
          end else begin
            page_err  <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
    wire       sel = word_q ? (off_q[OFF_W-1:1] == IDX[OFF_W-1:1]) : (off_q == IDX);
    wire [7:0] val = (word_q && IDX[0]) ? ld_data[15:8] : ld_data[7:0];
    always_ff @(posedge clk) begin
      if (!rst_n || arm) begin
        pgm_data[8*i +: 8] <= 8'hFF;
        pgm_loaded[i]      <= 1'b0;
      end else if (wr && sel) begin
        pgm_data[8*i +: 8] <= val;
        pgm_loaded[i]      <= 1'b1;
      end
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);
  a_r7_start_ends_window: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> (!loading && $past(loading)));
  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (pgm_loaded == '0 && (&pgm_data) && !page_err && loading));
  a_r10_frozen_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !arm) |=> ($stable(pgm_data) && $stable(pgm_loaded)));
  a_r5_flags_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !arm) |=> ((pgm_loaded & $past(pgm_loaded)) == $past(pgm_loaded)));
  a_r9_err_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(loading));
endmodule

// File: tb/sim_page_load_buf.sv
module sim_page_load_buf;
  localparam int TO = 20;
  logic clk = 0, rst_n = 0, arm = 0, arm_word = 0, tick = 0;
  logic ld_start = 0, ld_end = 0;
  logic [20:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic loading, pgm_start, page_err;
  logic [13:0] pgm_page;
  logic [1023:0] pgm_data;
  logic [127:0] pgm_loaded;

  page_load_buf #(.TIMEOUT_TICKS(TO)) u0 (
    .clk, .rst_n, .arm, .arm_word, .tick, .ld_start, .ld_addr, .ld_end, .ld_data,
    .loading, .pgm_start, .pgm_page, .pgm_data, .pgm_loaded, .page_err);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1, tick_cnt = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0] m_buf [128];
  bit m_flag [128];
  bit m_load, m_start, m_word, m_have, m_pend, m_err;
  int m_page, m_off, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_buf[k]) begin m_buf[k] = 8'hFF; m_flag[k] = 0; end
      m_load = 0; m_start = 0; m_word = 0; m_have = 0; m_pend = 0; m_err = 0;
      m_page = 0; m_off = 0; m_cnt = 0;
    end else begin
      bit hit, all;
      hit = m_load && ld_end && m_pend;
      all = 1;
      foreach (m_flag[k]) if (!m_flag[k]) all = 0;
      m_start = 0;
      if (arm) begin
        foreach (m_buf[k]) begin m_buf[k] = 8'hFF; m_flag[k] = 0; end
        m_load = 1; m_word = arm_word; m_have = 0; m_pend = 0; m_err = 0; m_cnt = 0;
      end else if (m_load && (all || (tick && m_cnt == TO - 1 && !hit))) begin
        m_load = 0; m_start = 1; m_pend = 0;
      end else if (m_load) begin
        if (hit) begin
          if (m_word) begin
            int b;
            b = (m_off / 2) * 2;
            m_buf[b] = ld_data[7:0];   m_flag[b] = 1;
            m_buf[b+1] = ld_data[15:8]; m_flag[b+1] = 1;
          end else begin
            m_buf[m_off] = ld_data[7:0]; m_flag[m_off] = 1;
          end
          m_cnt = 0; m_pend = 0;
        end else if (tick) m_cnt++;
        if (ld_start) begin
          int pg;
          pg = int'(ld_addr) / 128;
          if (!m_have || pg == m_page) begin
            m_pend = 1; m_off = int'(ld_addr) % 128; m_have = 1; m_page = pg;
          end else m_err = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1023:0] ed;
      logic [127:0] ef;
      for (int k = 0; k < 128; k++) begin ed[8*k +: 8] = m_buf[k]; ef[k] = m_flag[k]; end
      chk(loading == m_load, "R7 loading", 64'(loading), 64'(m_load));
      chk(pgm_start == m_start, "R11 pgm_start", 64'(pgm_start), 64'(m_start));
      chk(page_err == m_err, "R9 page_err", 64'(page_err), 64'(m_err));
      chk(pgm_page == 14'(m_page), "R9 pgm_page", 64'(pgm_page), 64'(m_page));
      chk(pgm_loaded == ef, "R6 pgm_loaded", 64'(pgm_loaded[63:0]), 64'(ef[63:0]));
      chk(pgm_data == ed, "R6 pgm_data", 64'(pgm_data[63:0]), 64'(ed[63:0]));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk) cyc++;
    chk(0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  task automatic nc();
    @(negedge clk);
    tick_cnt++;
    tick = (tick_cnt % tick_div == 0);
  endtask

  task automatic do_arm(input bit w);
    nc(); arm = 1; arm_word = w;
    nc(); arm = 0;
  endtask

  task automatic load(input logic [20:0] a, input logic [15:0] d);
    nc(); ld_start = 1; ld_addr = a;
    nc(); ld_start = 0; ld_addr = ~a;
    nc(); ld_end = 1; ld_data = d;
    nc(); ld_end = 0; ld_data = 16'h0;
  endtask

  task automatic wait_close(output int pulses);
    pulses = 0;
    for (int i = 0; i < 2000 && loading; i++) begin
      nc();
      if (pgm_start) pulses++;
    end
    for (int i = 0; i < 5; i++) begin
      nc();
      if (pgm_start) pulses++;
    end
  endtask

  function automatic logic [7:0] byte_at(input int k);
    return pgm_data[8*k +: 8];
  endfunction

  initial begin
    int p;
    logic [13:0] P  = 14'h123;
    logic [13:0] P2 = 14'h2A5;
    repeat (3) nc();
    chk(!loading && !pgm_start && !page_err, "R1 reset ctl", 64'({loading, pgm_start, page_err}), 0);
    chk(pgm_loaded == '0 && (&pgm_data) && pgm_page == 0, "R1 reset image", 64'(pgm_loaded[63:0]), 0);
    rst_n = 1;
    nc();

    // byte mode, scrambled order, overwrite, address moved between strobes
    do_arm(0);
    chk(loading == 1, "R2 window open", 64'(loading), 1);
    load({P, 7'd5}, 16'hAA11);
    load({P, 7'd0}, 16'hBB22);
    load({P, 7'd127}, 16'hCC33);
    load({P, 7'd5}, 16'hDD44);
    wait_close(p);
    chk(p == 1, "R11 one pulse", 64'(p), 1);
    chk(byte_at(5) == 8'h44, "R5 overwrite", 64'(byte_at(5)), 64'h44);
    chk(byte_at(0) == 8'h22 && byte_at(127) == 8'h33, "R3 byte place", 64'({byte_at(0), byte_at(127)}), 64'h2233);
    chk(byte_at(1) == 8'hFF && !pgm_loaded[1], "R6 unloaded FF", 64'(byte_at(1)), 64'hFF);
    chk($countones(pgm_loaded) == 3, "R6 flag count", 64'($countones(pgm_loaded)), 3);
    chk(pgm_page == P, "R9 page", 64'(pgm_page), 64'(P));

    // strobes with the window closed
    load({P, 7'd9}, 16'h0055);
    chk(byte_at(9) == 8'hFF && $countones(pgm_loaded) == 3, "R10 closed ignore", 64'(byte_at(9)), 64'hFF);

    // word mode, width toggled, foreign page, sparse ticks
    do_arm(1);
    arm_word = 0;
    chk(!page_err && pgm_loaded == '0, "R2 cleared", 64'(page_err), 0);
    load({P2, 6'd3, 1'b1}, 16'hBEEF);
    load({P2 + 14'd1, 6'd10, 1'b0}, 16'h1234);
    load({P2, 6'd12, 1'b0}, 16'h5678);
    tick_div = 3;
    wait_close(p);
    chk(byte_at(6) == 8'hEF && byte_at(7) == 8'hBE, "R4 word place", 64'({byte_at(6), byte_at(7)}), 64'hEFBE);
    chk(byte_at(24) == 8'h78 && byte_at(25) == 8'h56, "R10 width latched", 64'({byte_at(24), byte_at(25)}), 64'h7856);
    chk(page_err == 1, "R9 err set", 64'(page_err), 1);
    chk(byte_at(20) == 8'hFF && !pgm_loaded[21], "R9 refused", 64'(byte_at(20)), 64'hFF);
    chk(p == 1, "R11 one pulse word", 64'(p), 1);

    // full buffer, reverse byte order
    tick_div = 1;
    do_arm(0);
    chk(page_err == 0, "R2 err cleared", 64'(page_err), 0);
    for (int k = 127; k >= 0; k--) load({P, 7'(k)}, {8'h99, 8'(k) ^ 8'h5A});
    wait_close(p);
    chk(&pgm_loaded, "R8 all loaded", 64'($countones(pgm_loaded)), 128);
    chk(byte_at(77) == (8'd77 ^ 8'h5A), "R8 content", 64'(byte_at(77)), 64'(8'd77 ^ 8'h5A));
    chk(p == 1, "R8 one pulse", 64'(p), 1);

    // full buffer in word mode
    do_arm(1);
    for (int k = 0; k < 64; k++) load({P2, 6'(k), 1'b0}, {~8'(k), 8'(k)});
    wait_close(p);
    chk(&pgm_loaded && byte_at(63) == ~8'd31, "R4 word fill", 64'(byte_at(63)), 64'(~8'd31));

    // empty window, slow ticks
    tick_div = 2;
    do_arm(0);
    wait_close(p);
    chk(pgm_loaded == '0 && (&pgm_data), "R7 empty timeout", 64'($countones(pgm_loaded)), 0);
    chk(p == 1, "R11 empty pulse", 64'(p), 1);

    repeat (4) nc();
    finish_run();
  end
endmodule